// File: doc/BRIEF.md
# Keyed Hash Pad Block Generator

This block produces the inner or outer padded key block that a keyed hash construction feeds into its hash engine before the message or the inner digest. It keeps a 128-byte key store written one 32-bit word at a time. Each write can optionally be byte-reversed before it is stored. On a start request the block latches the pad choice, the digest mode and the key length code. It then streams the padded key as 64-bit words under a valid/ready handshake and flags the final word.

The key is extended with zero bytes up to the hash block size. Every byte is then combined by XOR with the pad constant. The stream is as long as the larger of the key and the block, so a key longer than the block is never cut short. A 128-byte key in the 64-byte-block mode produces sixteen words, not eight. The hash engine and its control sit downstream and are not part of the block.

Top module: `hpad_gen`

## Requirements
- R1: After reset, out_valid and out_last are low and every key store word is zero, so a stream started before any key write consists only of pad constant bytes.
- R2: With pad_outer low each emitted byte is the key byte XOR 0x36; with pad_outer high it is the key byte XOR 0x5c.
- R3: Key byte positions at or beyond the key length are treated as zero before the XOR, so they come out equal to the pad constant.
- R4: The number of words emitted is max(key bytes, block bytes)/8, where the block is 64 bytes for digest_mode 0 (256-bit) and 128 bytes for digest_mode 1 (384-bit), 2 (512-bit) and 3.
- R5: key_len codes 0, 1, 2, 3 select keys of 16, 32, 48 and 64 bytes; codes 4 to 7 select 128 bytes.
- R6: A key write stores key_wdata unchanged when key_swap is low and byte-reversed when key_swap is high. Key byte k is bits [8*(k%4)+7 : 8*(k%4)] of stored word k/4. Output word j carries key bytes 8j to 8j+7, with byte 8j in bits [7:0].
- R7: A start seen while idle raises out_valid in the next cycle with word 0. Words follow in ascending order, and out_last is high on the final word only.
- R8: While out_valid is high and out_ready is low, the word index holds and out_data stays on the same word.
- R9: A start asserted while a stream is in progress is ignored; the stream neither restarts nor lengthens.
- R10: pad_outer, digest_mode and key_len are sampled only when a start is taken; changes during a stream have no effect on it.
- R11: Once the last word is accepted, out_valid is low in the following cycle, and a new start is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_we | input | 1 | Key store write strobe |
| key_widx | input | 5 | Key store word index |
| key_wdata | input | 32 | Key word to store |
| key_swap | input | 1 | Byte-reverse the word before storing |
| start | input | 1 | Begin a pad stream (taken only when idle) |
| pad_outer | input | 1 | 0 = inner pad (0x36), 1 = outer pad (0x5c) |
| digest_mode | input | 2 | 0 = 256-bit, 1 = 384-bit, 2 = 512-bit, 3 treated as 128-byte block |
| key_len | input | 3 | Key length code |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | A padded word is presented |
| out_data | output | 64 | Padded key word |
| out_last | output | 1 | Current word is the final one of the stream |

## Verification
The hardest state to reach from the ports is a stream under heavy backpressure while the configuration inputs and start toggle underneath it. That case is needed to show that neither the latched settings nor the word index move. The bench reaches it with streams whose ready probability is low and whose mode, length, pad and start inputs are re-randomised every cycle. Each word shown is compared with a model built from the bench's own copy of the key bytes. Directed streams cover the 128-byte key in the small-block mode and the zero-key stream straight after reset.

// File: rtl/hpad_pkg.sv
// Package: shared constants and types for the pad generator.
// Assumes byte-wise pad constants as used by the keyed hash construction.
package hpad_pkg;
    localparam logic [7:0] PAD_INNER = 8'h36;
    localparam logic [7:0] PAD_OUTER = 8'h5c;

    typedef enum logic [1:0] {
        MODE_D256 = 2'd0,
        MODE_D384 = 2'd1,
        MODE_D512 = 2'd2,
        MODE_DRSV = 2'd3
    } hpad_mode_e;
endpackage

// File: rtl/hpad_key_store.sv
// Key store: KEY_WORDS words of WW bits, optional byte reversal on write,
// and a read port returning PER consecutive words packed as one output word.
// Assumes PER = OUT_W/WW is a power of two greater than one.
module hpad_key_store #(
    parameter int KEY_WORDS = 32,
    parameter int WW        = 32,
    parameter int OUT_W     = 64,
    localparam int KIW      = $clog2(KEY_WORDS),
    localparam int PER      = OUT_W / WW,
    localparam int PB       = $clog2(PER),
    localparam int RIW      = KIW - PB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [KIW-1:0]   widx,
    input  logic [WW-1:0]    wdata,
    input  logic             swap,
    input  logic [RIW-1:0]   ridx,
    output logic [OUT_W-1:0] rdata
);
    localparam int NB = WW / 8;

    logic [WW-1:0] mem [KEY_WORDS];
    logic [WW-1:0] wr_word;
    logic [WW-1:0] rev_word;

    // Byte-reverse the incoming word.
    for (genvar b = 0; b < NB; b++) begin : g_rev
        assign rev_word[b*8 +: 8] = wdata[(NB-1-b)*8 +: 8];
    end

    // Choose stored form of the incoming word.
    assign wr_word = swap ? rev_word : wdata;

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
        // Storage word g: cleared on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && (widx == KIW'(g)))
                mem[g] <= wr_word;
        end

        a_r6_write: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == KIW'(g)) |=>
                (mem[g] == ($past(swap) ? {<<8{$past(wdata)}} : $past(wdata))));
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && widx == KIW'(g)) |=> $stable(mem[g]));
    end

    // Read port: word ridx*PER+p lands in lane p.
    for (genvar p = 0; p < PER; p++) begin : g_rd
        assign rdata[p*WW +: WW] = mem[{ridx, PB'(p)}];
    end
endmodule

// File: rtl/hpad_len_calc.sv
// Length decoder: from digest mode and key length code, gives the number of
// output words covered by the key and the total stream length in words.
// Assumes key lengths are whole multiples of the output word size.
module hpad_len_calc
    import hpad_pkg::*;
#(
    parameter int OUT_BYTES = 8,
    parameter int KEY_UNIT  = 16,
    parameter int KEY_MAX   = 128,
    parameter int BLK_SMALL = 64,
    parameter int BLK_LARGE = 128,
    parameter int CW        = 5
) (
    input  logic [1:0]    mode,
    input  logic [2:0]    len_code,
    output logic [CW-1:0] key_words,
    output logic [CW-1:0] total_words
);
    localparam logic [CW-1:0] UNIT_W  = CW'(KEY_UNIT / OUT_BYTES);
    localparam logic [CW-1:0] KMAX_W  = CW'(KEY_MAX / OUT_BYTES);
    localparam logic [CW-1:0] BSMALL_W = CW'(BLK_SMALL / OUT_BYTES);
    localparam logic [CW-1:0] BLARGE_W = CW'(BLK_LARGE / OUT_BYTES);

    logic [CW-1:0] blk_words;

    // Decode key length code to key words.
    always_comb begin
        if (len_code[2]) begin
            key_words = KMAX_W;
        end else begin
            case (len_code[1:0])
                2'd0:    key_words = UNIT_W;
                2'd1:    key_words = UNIT_W * CW'(2);
                2'd2:    key_words = UNIT_W * CW'(3);
                default: key_words = UNIT_W * CW'(4);
            endcase
        end
    end

    // Block size by digest mode, then the larger of key and block.
    always_comb begin
        blk_words   = (hpad_mode_e'(mode) == MODE_D256) ? BSMALL_W : BLARGE_W;
        total_words = (key_words > blk_words) ? key_words : blk_words;
    end
endmodule

// File: rtl/hpad_seq.sv
// Stream sequencer: takes a start when idle, walks a word index from zero
// to total-1 under valid/ready, and flags the final word.
// Assumes total is stable from the cycle after take until the stream ends.
module hpad_seq #(
    parameter int IW = 4,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] total,
    input  logic          ready,
    output logic          take,
    output logic          valid,
    output logic          last,
    output logic [IW-1:0] idx
);
    logic xfer;

    // Start accepted only while idle.
    assign take = start && !valid;
    assign last = valid && ({1'b0, idx} == (total - CW'(1)));
    assign xfer = valid && ready;

    // Advance the index on each accepted word; drop valid after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            idx   <= '0;
        end else if (take) begin
            valid <= 1'b1;
            idx   <= '0;
        end else if (xfer) begin
            if (last) begin
                valid <= 1'b0;
                idx   <= '0;
            end else begin
                idx <= idx + IW'(1);
            end
        end
    end

    a_r7_first: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (valid && idx == '0));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(idx)));
    a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && last) |=> !valid);
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ({1'b0, idx} < total));
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && start && !ready) |=> $stable(idx));
endmodule

// File: rtl/hpad_gen.sv
// Top: keyed hash pad generator. Latches pad choice, mode and key length on
// a taken start, then streams zero-extended key words XORed with the pad.
// Assumes the key store is not rewritten while a stream is in progress.
module hpad_gen
    import hpad_pkg::*;
#(
    parameter int KEY_WORDS = 32,
    parameter int KEY_WW    = 32,
    parameter int OUT_W     = 64,
    localparam int KIW       = $clog2(KEY_WORDS),
    localparam int OUT_BYTES = OUT_W / 8,
    localparam int MAX_WORDS = KEY_WORDS * KEY_WW / OUT_W,
    localparam int IW        = $clog2(MAX_WORDS),
    localparam int CW        = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic [KIW-1:0]    key_widx,
    input  logic [KEY_WW-1:0] key_wdata,
    input  logic              key_swap,
    input  logic              start,
    input  logic              pad_outer,
    input  logic [1:0]        digest_mode,
    input  logic [2:0]        key_len,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_last
);
    logic             take;
    logic             outer_q;
    logic [1:0]       mode_q;
    logic [2:0]       len_q;
    logic [CW-1:0]    key_words;
    logic [CW-1:0]    total_words;
    logic [IW-1:0]    idx;
    logic [OUT_W-1:0] key_word;
    logic [7:0]       pad_byte;

    // Latch the stream configuration when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outer_q <= 1'b0;
            mode_q  <= 2'd0;
            len_q   <= 3'd0;
        end else if (take) begin
            outer_q <= pad_outer;
            mode_q  <= digest_mode;
            len_q   <= key_len;
        end
    end

    hpad_key_store #(
        .KEY_WORDS (KEY_WORDS),
        .WW        (KEY_WW),
        .OUT_W     (OUT_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (key_we),
        .widx  (key_widx),
        .wdata (key_wdata),
        .swap  (key_swap),
        .ridx  (idx),
        .rdata (key_word)
    );

    hpad_len_calc #(
        .OUT_BYTES (OUT_BYTES),
        .KEY_MAX   (KEY_WORDS * KEY_WW / 8),
        .CW        (CW)
    ) u_len (
        .mode        (mode_q),
        .len_code    (len_q),
        .key_words   (key_words),
        .total_words (total_words)
    );

    hpad_seq #(
        .IW (IW),
        .CW (CW)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .total (total_words),
        .ready (out_ready),
        .take  (take),
        .valid (out_valid),
        .last  (out_last),
        .idx   (idx)
    );

    // Zero-extend past the key, then XOR every byte with the pad constant.
    always_comb begin
        pad_byte = outer_q ? PAD_OUTER : PAD_INNER;
        if ({1'b0, idx} < key_words)
            out_data = key_word ^ {OUT_BYTES{pad_byte}};
        else
            out_data = {OUT_BYTES{pad_byte}};
    end

    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |=>
            ($stable(outer_q) && $stable(mode_q) && $stable(len_q)));
    a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_last));
endmodule

// File: tb/sim_hpad_gen.sv
module sim_hpad_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        key_we;
    logic [4:0]  key_widx;
    logic [31:0] key_wdata;
    logic        key_swap;
    logic        start;
    logic        pad_outer;
    logic [1:0]  digest_mode;
    logic [2:0]  key_len;
    logic        out_ready;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_last;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] keyb [128];

    always #(CLK_P/2) clk = ~clk;

    hpad_gen u0 (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_widx(key_widx),
        .key_wdata(key_wdata), .key_swap(key_swap), .start(start),
        .pad_outer(pad_outer), .digest_mode(digest_mode), .key_len(key_len),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int key_bytes(input logic [2:0] code);
        if (code >= 3'd4) return 128;
        return 16 * (int'(code) + 1);
    endfunction

    function automatic int blk_bytes(input logic [1:0] mode);
        return (mode == 2'd0) ? 64 : 128;
    endfunction

    function automatic logic [63:0] exp_word(input int j, input bit outer,
                                             input int nkey);
        logic [63:0] w;
        logic [7:0]  pb;
        pb = outer ? 8'h5c : 8'h36;
        for (int b = 0; b < 8; b++) begin
            logic [7:0] kb;
            kb = (8*j + b < nkey) ? keyb[8*j + b] : 8'h00;
            w[8*b +: 8] = kb ^ pb;
        end
        return w;
    endfunction

    task automatic wr_key(input int w, input logic [31:0] d, input bit sw);
        logic [31:0] st;
        @(negedge clk);
        key_we = 1'b1; key_widx = 5'(w); key_wdata = d; key_swap = sw;
        st = sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        for (int b = 0; b < 4; b++) keyb[4*w + b] = st[8*b +: 8];
        @(negedge clk);
        key_we = 1'b0;
    endtask

    // One stream: start, then walk words with random ready; optionally
    // disturb config and start during the stream (R9, R10).
    task automatic run_stream(input bit outer, input logic [1:0] mode,
                              input logic [2:0] code, input int rdy_pct,
                              input bit disturb, input string tag);
        int n, nk, idx, guard;
        nk = key_bytes(code);
        n  = ((nk > blk_bytes(mode)) ? nk : blk_bytes(mode)) / 8;
        @(negedge clk);
        start = 1'b1; pad_outer = outer; digest_mode = mode; key_len = code;
        out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(out_valid === 1'b1, {"R7 valid after start ", tag},
            64'(out_valid), 64'd1);
        idx = 0; guard = 0;
        while (idx < n && guard < 3000) begin
            guard++;
            out_ready = (int'($urandom % 100) < rdy_pct);
            if (disturb) begin
                pad_outer   = 1'($urandom);
                digest_mode = 2'($urandom);
                key_len     = 3'($urandom);
                start       = 1'($urandom);
            end
            #1;
            if (out_valid !== 1'b1) begin
                chk(1'b0, {"R7 valid dropped early ", tag}, 64'(idx), 64'(n));
                break;
            end
            // R2 R3 R6 R8: data of current word, held while not ready.
            chk(out_data === exp_word(idx, outer, nk),
                {"R2/R3 data ", tag}, out_data, exp_word(idx, outer, nk));
            chk(out_last === (idx == n - 1), {"R7 last flag ", tag},
                64'(out_last), 64'(idx == n - 1));
            if (out_ready) idx++;
            @(negedge clk);
        end
        start = 1'b0; out_ready = 1'b0;
        #1;
        // R4 R11: stream length and drop of valid after the last word.
        chk(out_valid === 1'b0, {"R11 idle after last ", tag},
            64'(out_valid), 64'd0);
        chk(idx == n, {"R4 word count ", tag}, 64'(idx), 64'(n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) keyb[i] = 8'h00;
        rst_n = 1'b0; key_we = 1'b0; key_widx = '0; key_wdata = '0;
        key_swap = 1'b0; start = 1'b0; pad_outer = 1'b0; digest_mode = '0;
        key_len = '0; out_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid === 1'b0 && out_last === 1'b0, "R1 reset outputs",
            {62'd0, out_valid, out_last}, 64'd0);
        // R1: zero key store gives pure pad bytes.
        run_stream(1'b0, 2'd0, 3'd0, 100, 1'b0, "R1 zero key");
        run_stream(1'b1, 2'd2, 3'd4, 100, 1'b0, "R1 zero key outer");

        // R6: directed swap and no-swap writes, then random fill.
        wr_key(0, 32'h11223344, 1'b1);
        wr_key(1, 32'h55667788, 1'b0);
        for (int w = 2; w < 32; w++) wr_key(w, $urandom, 1'($urandom));
        run_stream(1'b0, 2'd0, 3'd0, 100, 1'b0, "R6 byte order");

        // R4 R5 directed lengths.
        run_stream(1'b0, 2'd0, 3'd4, 100, 1'b0, "R4 long key small block");
        run_stream(1'b1, 2'd0, 3'd1, 100, 1'b0, "R3 short key outer");
        run_stream(1'b0, 2'd1, 3'd0, 100, 1'b0, "R4 384 short key");
        run_stream(1'b1, 2'd2, 3'd3, 100, 1'b0, "R5 code3 512");
        run_stream(1'b0, 2'd3, 3'd6, 100, 1'b0, "R5 code6 mode3");
        run_stream(1'b1, 2'd0, 3'd2, 100, 1'b0, "R5 code2 256");
        // R8 heavy backpressure; R9 R10 disturbance.
        run_stream(1'b0, 2'd0, 3'd2, 15, 1'b0, "R8 backpressure");
        run_stream(1'b1, 2'd1, 3'd1, 20, 1'b1, "R9/R10 disturb");
        run_stream(1'b0, 2'd0, 3'd4, 30, 1'b1, "R9/R10 disturb long");

        // Random streams with occasional key rewrites.
        for (int t = 0; t < 24; t++) begin
            if (($urandom % 3) == 0)
                wr_key(int'($urandom % 32), $urandom, 1'($urandom));
            run_stream(1'($urandom), 2'($urandom), 3'($urandom),
                       20 + int'($urandom % 81), 1'($urandom), "random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule